// File: doc/BRIEF.md
# GPIO Port Control Register File

This block holds the per-pin control state of a general-purpose I/O port with `NPINS` pins (32 by default). Software reaches it through a single-cycle synchronous register bus. Every control field has one address where ones set bits and a second address where ones clear bits, so no read-modify-write is needed. A third address returns the current state. The controls cover five things per pin: whether the port or a peripheral owns the pin, the output driver enable, the output level, pull-up and pull-down selection, and the input filter choice (glitch or debounce).

The output level can also be loaded directly. That load is gated per pin by a write mask with its own set and clear addresses. The pull controls obey an exclusivity rule: a pull cannot be turned on while the opposite pull on that pin is on. The pin levels pass through a two-flop synchronizer and can always be read back, whatever the direction of the pin. The pad-side outputs are registered.

Top module: `gpio_port_regs`

## Requirements
- R1: While reset is applied and afterwards until written, the state is as follows. Every pin is port-owned. Every output driver is off. The output level is 0, the direct-write mask is 0, the debounce select is 0, every pull-up is on and every pull-down is off. One cycle after reset, the pad outputs reflect this state.
- R2: A write to LEVEL_SET (0x20) sets the output level of the pins whose data bits are 1. A write to LEVEL_CLR (0x24) clears those pins. Pins whose data bits are 0 keep their level.
- R3: A write to LEVEL_DATA (0x28) loads the data bit into the output level only on pins whose mask bit is 1. Other pins keep their level. The mask is set at MASK_SET (0x30), cleared at MASK_CLR (0x34) and read at MASK_STAT (0x38).
- R4: The output driver enable is set at DRIVE_SET (0x10), cleared at DRIVE_CLR (0x14) and read at DRIVE_STAT (0x18).
- R5: Ownership is set at OWN_SET (0x00), cleared at OWN_CLR (0x04) and read at OWN_STAT (0x08). On a port-owned pin, pad_out and pad_oe come from the output level and the driver enable. On any other pin, they come from periph_out and periph_oe.
- R6: Pull-ups are set at PU_SET (0x40), cleared at PU_CLR (0x44) and read at PU_STAT (0x48). Pull-downs use PD_SET (0x50), PD_CLR (0x54) and PD_STAT (0x58). A set request has no effect on a pin whose opposite pull is on, and no pin ever has both pulls on.
- R7: The debounce select is set at FILT_SET (0x60), cleared at FILT_CLR (0x64) and read at FILT_STAT (0x68). A bit value of 1 selects debounce and 0 selects glitch filtering. The select drives pad_debounce.
- R8: Set and clear addresses read as 0. So does any address that is not word aligned, that is not listed here, or that has an address bit above bit 6 set. A write to a status address other than LEVEL_DATA changes nothing.
- R9: bus_rdata carries the result of a read one cycle after the cycle in which bus_rd is sampled high. It is 0 in the cycle after a cycle with no read.
- R10: PIN_STAT (0x78) returns the pin levels through a two-flop synchronizer, whatever the driver enable. A pin change made before clock edge 1 is returned by a read sampled at edge 3 or later, and not by a read sampled at edge 1 or edge 2.
- R11: pad_out, pad_oe, pad_pu, pad_pd and pad_debounce change one clock edge after the state register that feeds them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW | Byte address of the register access |
| bus_wdata | input | NPINS | Write data, one bit per pin |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | NPINS | Read data, valid the cycle after the read |
| pin_in | input | NPINS | Asynchronous pin levels from the pads |
| periph_out | input | NPINS | Output level from the peripheral owner |
| periph_oe | input | NPINS | Output enable from the peripheral owner |
| pad_out | output | NPINS | Registered output level to the pads |
| pad_oe | output | NPINS | Registered output enable to the pads |
| pad_pu | output | NPINS | Registered pull-up enable |
| pad_pd | output | NPINS | Registered pull-down enable |
| pad_debounce | output | NPINS | Registered filter select, 1 means debounce |

## Verification
The hardest state to reach is a pin whose pull-down is on. After reset every pull-up is on, so a pull-down request is refused. The stimulus first shows that refusal, then clears some pull-ups, sets the pull-downs, and finally tries to set the pull-ups back to show that the reverse request is refused as well. The masked direct write needs a similar setup. The stimulus first issues a direct write with an empty mask to show it does nothing, then loads a partial mask and checks the merged level. The synchronizer latency is measured by holding a read of the pin status across three edges after a pin change.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int NGRP = 8;
  localparam int GW   = 3;

  localparam int GRP_OWN  = 0;
  localparam int GRP_DRV  = 1;
  localparam int GRP_LVL  = 2;
  localparam int GRP_MASK = 3;
  localparam int GRP_PU   = 4;
  localparam int GRP_PD   = 5;
  localparam int GRP_FILT = 6;
  localparam int GRP_PIN  = 7;

  localparam logic [1:0] SUB_SET  = 2'd0;
  localparam logic [1:0] SUB_CLR  = 2'd1;
  localparam logic [1:0] SUB_STAT = 2'd2;

  function automatic logic [31:0] reg_addr(input int grp, input logic [1:0] sub);
    return 32'(grp * 16) + {28'd0, sub, 2'b00};
  endfunction

  function automatic logic grp_rst_bit(input int grp);
    return (grp == GRP_OWN) || (grp == GRP_PU);
  endfunction
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_port_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0]   addr,
  input  logic            wr,
  input  logic            rd,
  output logic [NGRP-1:0] set_stb,
  output logic [NGRP-1:0] clr_stb,
  output logic            ld_stb,
  output logic            rd_stat,
  output logic [GW-1:0]   rd_grp
);
  logic          hit;
  logic [GW-1:0] grp;
  logic [1:0]    sub;

  assign hit    = (addr[AW-1:4+GW] == '0) && (addr[1:0] == 2'b00);
  assign grp    = addr[4+GW-1:4];
  assign sub    = addr[3:2];
  assign rd_grp = grp;

  assign ld_stb  = wr && hit && (grp == GW'(GRP_LVL)) && (sub == SUB_STAT);
  assign rd_stat = rd && hit && (sub == SUB_STAT);

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign set_stb[g] = wr && hit && (grp == GW'(g)) && (sub == SUB_SET);
    assign clr_stb[g] = wr && hit && (grp == GW'(g)) && (sub == SUB_CLR);
  end
endmodule

// File: rtl/gpio_sc_reg.sv
module gpio_sc_reg #(
  parameter int W = 32,
  parameter logic RST_BIT = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic         ld_stb,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] ld_mask,
  input  logic [W-1:0] set_allow,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt;

  always_comb begin
    nxt = q;
    if (set_stb) nxt = q | (wdata & set_allow);
    if (clr_stb) nxt = q & ~wdata;
    if (ld_stb)  nxt = (q & ~ld_mask) | (wdata & ld_mask);
  end

  always_ff @(posedge clk) begin
    if (rst) q <= {W{RST_BIT}};
    else     q <= nxt;
  end
endmodule

// File: rtl/gpio_pull_ctrl.sv
module gpio_pull_ctrl #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pu_set,
  input  logic         pu_clr,
  input  logic         pd_set,
  input  logic         pd_clr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] pu_q,
  output logic [W-1:0] pd_q
);
  gpio_sc_reg #(.W(W), .RST_BIT(1'b1)) u_pu (
    .clk(clk), .rst(rst), .set_stb(pu_set), .clr_stb(pu_clr), .ld_stb(1'b0),
    .wdata(wdata), .ld_mask('0), .set_allow(~pd_q), .q(pu_q)
  );

  gpio_sc_reg #(.W(W), .RST_BIT(1'b0)) u_pd (
    .clk(clk), .rst(rst), .set_stb(pd_set), .clr_stb(pd_clr), .ld_stb(1'b0),
    .wdata(wdata), .ld_mask('0), .set_allow(~pu_q), .q(pd_q)
  );
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int AW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    bus_addr,
  input  logic [NPINS-1:0] bus_wdata,
  input  logic             bus_wr,
  input  logic             bus_rd,
  output logic [NPINS-1:0] bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] periph_out,
  input  logic [NPINS-1:0] periph_oe,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_pu,
  output logic [NPINS-1:0] pad_pd,
  output logic [NPINS-1:0] pad_debounce
);
  logic [NGRP-1:0]  set_stb;
  logic [NGRP-1:0]  clr_stb;
  logic             ld_stb;
  logic             rd_stat;
  logic [GW-1:0]    rd_grp;
  logic [NPINS-1:0] st [NGRP];
  logic [NPINS-1:0] pin_sync;
  logic [NPINS-1:0] own_q, oe_q, odata_q, wmask_q, pu_q, pd_q, filt_q;

  gpio_addr_dec #(.AW(AW)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .set_stb(set_stb), .clr_stb(clr_stb), .ld_stb(ld_stb),
    .rd_stat(rd_stat), .rd_grp(rd_grp)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_ctl
    if (g != GRP_PU && g != GRP_PD && g != GRP_PIN) begin : g_sc
      gpio_sc_reg #(.W(NPINS), .RST_BIT(grp_rst_bit(g))) u_reg (
        .clk(clk), .rst(rst),
        .set_stb(set_stb[g]), .clr_stb(clr_stb[g]),
        .ld_stb((g == GRP_LVL) ? ld_stb : 1'b0),
        .wdata(bus_wdata),
        .ld_mask((g == GRP_LVL) ? wmask_q : '0),
        .set_allow('1),
        .q(st[g])
      );
    end
  end

  gpio_pull_ctrl #(.W(NPINS)) u_pull (
    .clk(clk), .rst(rst),
    .pu_set(set_stb[GRP_PU]), .pu_clr(clr_stb[GRP_PU]),
    .pd_set(set_stb[GRP_PD]), .pd_clr(clr_stb[GRP_PD]),
    .wdata(bus_wdata), .pu_q(pu_q), .pd_q(pd_q)
  );

  gpio_sync2 #(.W(NPINS)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_sync)
  );

  assign st[GRP_PU]  = pu_q;
  assign st[GRP_PD]  = pd_q;
  assign st[GRP_PIN] = pin_sync;

  assign own_q   = st[GRP_OWN];
  assign oe_q    = st[GRP_DRV];
  assign odata_q = st[GRP_LVL];
  assign wmask_q = st[GRP_MASK];
  assign filt_q  = st[GRP_FILT];

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_stat ? st[rd_grp] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out      <= '0;
      pad_oe       <= '0;
      pad_pu       <= '1;
      pad_pd       <= '0;
      pad_debounce <= '0;
    end else begin
      pad_out      <= (own_q & odata_q) | (~own_q & periph_out);
      pad_oe       <= (own_q & oe_q)    | (~own_q & periph_oe);
      pad_pu       <= pu_q;
      pad_pd       <= pd_q;
      pad_debounce <= filt_q;
    end
  end
endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int AW    = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [AW-1:0]    bus_addr,
  input logic [NPINS-1:0] bus_wdata,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [NPINS-1:0] bus_rdata,
  input logic [NPINS-1:0] own_q,
  input logic [NPINS-1:0] oe_q,
  input logic [NPINS-1:0] odata_q,
  input logic [NPINS-1:0] wmask_q,
  input logic [NPINS-1:0] pu_q,
  input logic [NPINS-1:0] pd_q,
  input logic [NPINS-1:0] filt_q,
  input logic [NPINS-1:0] pad_out,
  input logic [NPINS-1:0] pad_pu
);
  localparam logic [AW-1:0] A_LSET = AW'(reg_addr(GRP_LVL, SUB_SET));
  localparam logic [AW-1:0] A_LCLR = AW'(reg_addr(GRP_LVL, SUB_CLR));
  localparam logic [AW-1:0] A_LDAT = AW'(reg_addr(GRP_LVL, SUB_STAT));

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (own_q == '1 && oe_q == '0 && odata_q == '0 && wmask_q == '0 &&
             pu_q == '1 && pd_q == '0 && filt_q == '0));

  a_r2_set_level: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_LSET) |=> ((odata_q & $past(bus_wdata)) == $past(bus_wdata)));

  a_r2_clr_level: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_LCLR) |=> ((odata_q & $past(bus_wdata)) == '0));

  a_r3_masked_load: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_LDAT) |=> (((odata_q ^ $past(odata_q)) & ~$past(wmask_q)) == '0));

  a_r6_pull_exclusive: assert property (@(posedge clk) disable iff (rst)
    ((pu_q & pd_q) == '0));

  a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));

  a_r5_owned_level: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((pad_out ^ $past(odata_q)) & $past(own_q)) == '0));

  a_r11_pull_lag: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pad_pu == $past(pu_q)));
endmodule

bind gpio_port_regs gpio_port_regs_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .own_q(own_q), .oe_q(oe_q), .odata_q(odata_q), .wmask_q(wmask_q),
  .pu_q(pu_q), .pd_q(pd_q), .filt_q(filt_q),
  .pad_out(pad_out), .pad_pu(pad_pu)
);

// File: tb/sim_gpio_port_regs.sv
module sim_gpio_port_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] periph_out = '0;
  logic [31:0] periph_oe = '0;
  logic [31:0] pad_out, pad_oe, pad_pu, pad_pd, pad_debounce;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  gpio_port_regs u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .periph_out(periph_out), .periph_oe(periph_oe), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_debounce(pad_debounce)
  );

  // {is_read, addr[7:0], wdata, expected}
  localparam int NV = 32;
  localparam logic [72:0] VEC [NV] = '{
    {1'b1, 8'h08, 32'h0, 32'hFFFFFFFF},   // R1 owned
    {1'b1, 8'h48, 32'h0, 32'hFFFFFFFF},   // R1 pull-ups on
    {1'b1, 8'h58, 32'h0, 32'h00000000},   // R1 pull-downs off
    {1'b1, 8'h28, 32'h0, 32'h00000000},   // R1 level zero
    {1'b0, 8'h20, 32'h0000F00F, 32'h0},
    {1'b1, 8'h28, 32'h0, 32'h0000F00F},   // R2 set
    {1'b0, 8'h24, 32'h00000003, 32'h0},
    {1'b1, 8'h28, 32'h0, 32'h0000F00C},   // R2 clear
    {1'b1, 8'h20, 32'h0, 32'h00000000},   // R8 set addr reads 0
    {1'b0, 8'h28, 32'hFFFFFFFF, 32'h0},
    {1'b1, 8'h28, 32'h0, 32'h0000F00C},   // R3 empty mask
    {1'b0, 8'h30, 32'h000000FF, 32'h0},
    {1'b0, 8'h28, 32'h000000A5, 32'h0},
    {1'b1, 8'h28, 32'h0, 32'h0000F0A5},   // R3 merged
    {1'b1, 8'h38, 32'h0, 32'h000000FF},   // R3 mask stat
    {1'b0, 8'h50, 32'h0000000F, 32'h0},
    {1'b1, 8'h58, 32'h0, 32'h00000000},   // R6 refused
    {1'b0, 8'h44, 32'h00000003, 32'h0},
    {1'b0, 8'h50, 32'h0000000F, 32'h0},
    {1'b1, 8'h58, 32'h0, 32'h00000003},   // R6 partial
    {1'b0, 8'h40, 32'h0000000F, 32'h0},
    {1'b1, 8'h48, 32'h0, 32'hFFFFFFFC},   // R6 reverse refused
    {1'b0, 8'h10, 32'h00000F0F, 32'h0},
    {1'b0, 8'h14, 32'h0000000F, 32'h0},
    {1'b1, 8'h18, 32'h0, 32'h00000F00},   // R4
    {1'b0, 8'h60, 32'h80000001, 32'h0},
    {1'b1, 8'h68, 32'h0, 32'h80000001},   // R7
    {1'b1, 8'h7C, 32'h0, 32'h00000000},   // R8 unmapped
    {1'b1, 8'h64, 32'h0, 32'h00000000},   // R8 clear addr
    {1'b1, 8'h0A, 32'h0, 32'h00000000},   // R8 misaligned
    {1'b0, 8'h08, 32'h00000000, 32'h0},
    {1'b1, 8'h08, 32'h0, 32'hFFFFFFFF}    // R8 stat write ignored
  };
  localparam string TAG [NV] = '{
    "R1","R1","R1","R1","-","R2","-","R2","R8","-","R3","-","-","R3","R3","-",
    "R6","-","-","R6","-","R6","-","-","R4","-","R7","R8","R8","R8","-","R8"
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 pad state out of reset
    chk("R1", pad_oe, 32'h0);
    chk("R1", pad_pu, 32'hFFFFFFFF);
    chk("R1", pad_out, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][72]) begin
        rd({24'd0, VEC[i][71:64]}, v);
        chk(TAG[i], v, VEC[i][31:0]);
      end else begin
        wr({24'd0, VEC[i][71:64]}, VEC[i][63:32]);
      end
    end

    // R8: upper address bit makes the access unmapped
    rd(32'h1000_0008, v);
    chk("R8", v, 32'h0);

    // R9: no read in previous cycle gives zero
    @(negedge clk);
    chk("R9", bus_rdata, 32'h0);

    // R4 R6 R7 R11 pad outputs reflect state
    chk("R4", pad_oe, 32'h00000F00);
    chk("R11", pad_out, 32'h0000F0A5);
    chk("R6", pad_pu, 32'hFFFFFFFC);
    chk("R6", pad_pd, 32'h00000003);
    chk("R7", pad_debounce, 32'h80000001);

    // R5 lower half handed to the peripheral
    periph_out = 32'h12345678;
    periph_oe  = 32'h0000FFF0;
    wr(32'h04, 32'h0000FFFF);
    @(negedge clk);
    chk("R5", pad_out, 32'h00005678);
    chk("R5", pad_oe, 32'h0000FFF0);

    // R11 one-edge lag of the pad output after a level set
    wr(32'h20, 32'h00010000);
    chk("R11", pad_out, 32'h00005678);
    @(negedge clk);
    chk("R11", pad_out, 32'h00015678);

    // R10 synchronizer latency, pins read with drivers off
    wr(32'h14, 32'hFFFFFFFF);
    pin_in = 32'hA5A55A5A;
    bus_addr = 32'h78; bus_rd = 1'b1;
    @(negedge clk);
    chk("R10", bus_rdata, 32'h0);
    @(negedge clk);
    chk("R10", bus_rdata, 32'h0);
    @(negedge clk);
    chk("R10", bus_rdata, 32'hA5A55A5A);
    bus_rd = 1'b0;

    // R1 reset again restores state
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    rd(32'h28, v);
    chk("R1", v, 32'h0);
    rd(32'h38, v);
    chk("R1", v, 32'h0);

    finish_run();
  end
endmodule